// File: doc/BRIEF.md
# Low-Frequency Clock Timer with Coherent Two-Nibble Readout

This block keeps slow time for a small microcontroller. It runs from a 32.768 kHz crystal clock. A gated prescaler divides that clock by 128 to get a 256 Hz step. Each step advances an 8-bit binary count. Bit 0 of the count toggles at 128 Hz and bit 7 toggles at 1 Hz. Software turns the prescaler on with an enable bit and pauses counting with a run/stop input. A clear input returns the count to zero.

Software reads the count through a 4-bit register read port, as two nibbles at two addresses. Reading the low nibble also copies the live high nibble into a holding register. The high-nibble address always returns that held copy. A carry between the two reads therefore cannot corrupt the combined value. Four counter taps (32 Hz, 8 Hz, 2 Hz and 1 Hz) raise a one-cycle pulse and a sticky flag on their falling edge. Software clears the flags by writing to a third address.

Top module: `ct_clock_timer`

## Requirements
- R1: While `rst` is high and after it falls, the count, the holding register, `irq_pulse` and `irq_flag` are all zero.
- R2: With `clk_en` and `run` both 1, the count rises by one on every 128th rising edge. It wraps from 0xFF to 0x00.
- R3: While `clk_en` is 0, neither the prescaler phase nor the count moves. Counting picks up from the same phase when the enable returns.
- R4: While `run` is 0 and `clk_en` is 1, the prescaler keeps its phase running but the count holds.
- R5: A read (`bus_rd`=1) at address 0 returns count bits 3..0 on `bus_rdata` 3..0 in the same cycle.
- R6: A read at address 0 copies count bits 7..4 into the holding register at the edge that ends the read. A carry at that same edge does not change the copied value. A read at address 1 returns the holding register (count bit 4 on `bus_rdata`[0]) and never the live bits.
- R7: The holding register keeps its value until the next read at address 0.
- R8: A one-cycle `cnt_clr` clears the count, the holding register and the prescaler phase. The count then reads 1 only after another 128 enabled edges.
- R9: When count bit 2, 4, 6 or 7 falls by counting, `irq_pulse` bit 0, 1, 2 or 3 respectively is 1 for exactly one cycle, and the matching `irq_flag` bit is set.
- R10: A write (`bus_wr`=1) at address 2 clears each `irq_flag` bit whose `bus_wdata` bit is 1. Writes at other addresses leave the flags unchanged.
- R11: `bus_rdata` is zero when `bus_rd` is 0 or the address is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Gates the clock to the prescaler |
| run | input | 1 | 1 lets the count advance, 0 holds it |
| cnt_clr | input | 1 | Clears count, holding register and prescaler |
| bus_addr | input | 2 | 0 low nibble, 1 held high nibble, 2 flag clear |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data (flag clear mask) |
| bus_rdata | output | 4 | Read data, combinational |
| irq_pulse | output | 4 | One-cycle falling-edge pulses of the 32/8/2/1 Hz taps |
| irq_flag | output | 4 | Sticky flags of the same taps |

## Verification
- **Read data:** `bus_rdata` is combinational, so a read result is valid in the cycle the strobe is high. The bench drives every input at the falling clock edge and samples the read data 1 ns later.
- **Registered state:** The count, the holding register, the pulses and the flags all change at the rising edge that ends a step or a read. The bench checks these only after that edge, at the next falling edge.
- **Step counts:** A count step comes on exactly the 128th enabled rising edge after a clear. The bench runs an exact number of enabled edges, then drops `clk_en` before it reads, so the reads themselves do not shift the prescaler.
- **Carry during a read:** One scenario issues the low read in the very cycle whose edge carries into the high nibble. This shows that the held copy is the value from before the carry.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int CT_CNT_W = 8;
    localparam int CT_NIB_W = CT_CNT_W / 2;
    localparam int CT_TAP_N = 4;

    typedef enum logic [1:0] {
        CT_ADDR_LO   = 2'd0,
        CT_ADDR_HI   = 2'd1,
        CT_ADDR_IRQ  = 2'd2,
        CT_ADDR_NONE = 2'd3
    } ct_addr_e;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_irq;
    } ct_bus_dec_t;

    // counter bit whose falling edge drives interrupt tap i
    function automatic int tap_pos(input int i);
        case (i)
            0:       return 2;
            1:       return 4;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

    function automatic ct_bus_dec_t bus_decode(input logic [1:0] addr,
                                               input logic rd,
                                               input logic wr);
        ct_bus_dec_t d;
        d.rd_lo  = rd && (ct_addr_e'(addr) == CT_ADDR_LO);
        d.rd_hi  = rd && (ct_addr_e'(addr) == CT_ADDR_HI);
        d.wr_irq = wr && (ct_addr_e'(addr) == CT_ADDR_IRQ);
        return d;
    endfunction

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic enable,
    output logic tick
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase_q;

    assign tick = enable && (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (enable) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ct_counter.sv
module ct_counter
    import ct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                advance,
    input  logic                cap_hi,
    output logic [CT_CNT_W-1:0] count,
    output logic [CT_NIB_W-1:0] hold,
    output logic [CT_TAP_N-1:0] fall
);
    logic [CT_CNT_W-1:0] count_q;
    logic [CT_NIB_W-1:0] hold_q;
    logic [CT_CNT_W-1:0] count_nxt;
    logic                step;

    assign step      = advance && !clr;
    assign count_nxt = count_q + 1'b1;

    for (genvar i = 0; i < CT_TAP_N; i++) begin : g_tap
        localparam int P = tap_pos(i);
        assign fall[i] = step && count_q[P] && !count_nxt[P];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold_q <= '0;
        end else if (cap_hi) begin
            hold_q <= count_q[CT_CNT_W-1:CT_NIB_W];
        end
    end

    assign count = count_q;
    assign hold  = hold_q;
endmodule

// File: rtl/ct_irq.sv
module ct_irq
    import ct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CT_TAP_N-1:0] fall,
    input  logic                clr_en,
    input  logic [CT_TAP_N-1:0] clr_mask,
    output logic [CT_TAP_N-1:0] pulse,
    output logic [CT_TAP_N-1:0] flag
);
    logic [CT_TAP_N-1:0] pulse_q;
    logic [CT_TAP_N-1:0] flag_q;
    logic [CT_TAP_N-1:0] kill;

    assign kill = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
            flag_q  <= '0;
        end else begin
            pulse_q <= fall;
            flag_q  <= (flag_q & ~kill) | fall;
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
endmodule

// File: rtl/ct_clock_timer.sv
module ct_clock_timer
    import ct_pkg::*;
#(
    parameter int PRESCALE_DIV = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       run,
    input  logic       cnt_clr,
    input  logic [1:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    output logic [3:0] irq_pulse,
    output logic [3:0] irq_flag
);
    ct_bus_dec_t         dec;
    logic                tick;
    logic [CT_CNT_W-1:0] cnt_q;
    logic [CT_NIB_W-1:0] hold_q;
    logic [CT_TAP_N-1:0] tap_fall;

    assign dec = bus_decode(bus_addr, bus_rd, bus_wr);

    ct_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (cnt_clr),
        .enable  (clk_en),
        .tick    (tick)
    );

    ct_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .advance (tick && run),
        .cap_hi  (dec.rd_lo),
        .count   (cnt_q),
        .hold    (hold_q),
        .fall    (tap_fall)
    );

    ct_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .fall     (tap_fall),
        .clr_en   (dec.wr_irq),
        .clr_mask (bus_wdata),
        .pulse    (irq_pulse),
        .flag     (irq_flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.rd_lo) begin
            bus_rdata = cnt_q[CT_NIB_W-1:0];
        end else if (dec.rd_hi) begin
            bus_rdata = hold_q;
        end
    end
endmodule

// File: rtl/ct_clock_timer_chk.sv
module ct_clock_timer_chk
    import ct_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                clk_en,
    input logic                run,
    input logic                cnt_clr,
    input logic [1:0]          bus_addr,
    input logic                bus_rd,
    input logic [3:0]          bus_rdata,
    input logic [3:0]          irq_pulse,
    input logic [3:0]          irq_flag,
    input logic                tick,
    input logic [CT_CNT_W-1:0] cnt_q,
    input logic [CT_NIB_W-1:0] hold_q
);
    logic rd_lo;
    assign rd_lo = bus_rd && (bus_addr == 2'd0);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !cnt_clr) |=> (cnt_q == 8'($past(cnt_q) + 8'd1)));

    p_off_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !cnt_clr) |=> $stable(cnt_q));

    p_stop_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_clr) |=> $stable(cnt_q));

    p_hold_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !cnt_clr) |=> (hold_q == $past(cnt_q[7:4])));

    p_hold_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_lo && !cnt_clr) |=> $stable(hold_q));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (cnt_q == '0 && hold_q == '0));

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse != '0) |=> (irq_pulse == '0));

    p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
        ((irq_flag & irq_pulse) == irq_pulse));

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind ct_clock_timer ct_clock_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .run       (run),
    .cnt_clr   (cnt_clr),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .hold_q    (hold_q)
);

// File: tb/ct_clock_timer_test.sv
module ct_clock_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       run = 1'b0;
    logic       cnt_clr = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic [3:0] irq_pulse;
    logic [3:0] irq_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ct_clock_timer uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .run(run), .cnt_clr(cnt_clr),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_bus(input logic [1:0] a, output logic [3:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_addr = 2'd3;
    endtask

    task automatic wr_bus(input logic [1:0] a, input logic [3:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 2'd3;
    endtask

    task automatic clear_count();
        cnt_clr = 1'b1;
        step(1);
        cnt_clr = 1'b0;
    endtask

    task automatic run_edges(input int n);
        clk_en = 1'b1;
        run    = 1'b1;
        step(n);
        clk_en = 1'b0;
    endtask

    task automatic snapshot(output logic [7:0] v);
        logic [3:0] lo, hi;
        rd_bus(2'd0, lo);
        rd_bus(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pulse in reset", int'(irq_pulse), 0);
        chk("R1 flag in reset", int'(irq_flag), 0);
        rst = 1'b0;
        step(1);
        snapshot(v);
        chk("R1 count after reset", int'(v), 0);
        chk("R1 flag after reset", int'(irq_flag), 0);
    endtask

    task automatic t_count();
        logic [7:0] v;
        clear_count();
        run_edges(127);
        snapshot(v);
        chk("R2 count after 127 edges", int'(v), 0);
        run_edges(1);
        snapshot(v);
        chk("R2 count after 128 edges", int'(v), 1);
        run_edges(4 * 128);
        snapshot(v);
        chk("R2 count after 640 edges", int'(v), 5);
    endtask

    task automatic t_enable_gate();
        logic [7:0] v;
        clear_count();
        run_edges(100);
        run = 1'b1;
        step(200);
        snapshot(v);
        chk("R3 frozen while clock off", int'(v), 0);
        run_edges(27);
        snapshot(v);
        chk("R3 phase kept, 127 enabled", int'(v), 0);
        run_edges(1);
        snapshot(v);
        chk("R3 phase kept, 128 enabled", int'(v), 1);
    endtask

    task automatic t_stop();
        logic [7:0] v;
        clear_count();
        clk_en = 1'b1;
        run    = 1'b0;
        step(300);
        clk_en = 1'b0;
        snapshot(v);
        chk("R4 count held while stopped", int'(v), 0);
        run_edges(83);
        snapshot(v);
        chk("R4 prescaler ran while stopped (83)", int'(v), 0);
        run_edges(1);
        snapshot(v);
        chk("R4 prescaler ran while stopped (84)", int'(v), 1);
    endtask

    task automatic t_hold();
        logic [3:0] d;
        clear_count();
        run_edges(15 * 128);
        rd_bus(2'd0, d);
        chk("R5 low nibble", int'(d), 4'hF);
        run_edges(128);
        rd_bus(2'd1, d);
        chk("R6 high read returns held not live", int'(d), 0);
        step(5);
        rd_bus(2'd1, d);
        chk("R7 hold kept across reads", int'(d), 0);
        rd_bus(2'd0, d);
        chk("R5 low nibble after carry", int'(d), 0);
        rd_bus(2'd1, d);
        chk("R6 high after new capture", int'(d), 1);
    endtask

    task automatic t_carry_during_read();
        logic [3:0] d;
        logic [7:0] v;
        clear_count();
        run_edges(15 * 128 + 127);
        clk_en   = 1'b1;
        run      = 1'b1;
        bus_addr = 2'd0;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        clk_en   = 1'b0;
        chk("R6 low read at carry edge", int'(d), 4'hF);
        rd_bus(2'd1, d);
        chk("R6 held high is pre-carry", int'(d), 0);
        snapshot(v);
        chk("R6 fresh snapshot after carry", int'(v), 8'h10);
    endtask

    task automatic t_clear();
        logic [3:0] d;
        logic [7:0] v;
        clear_count();
        run_edges(16 * 128 + 50);
        rd_bus(2'd0, d);
        clear_count();
        rd_bus(2'd1, d);
        chk("R8 hold cleared", int'(d), 0);
        run_edges(127);
        snapshot(v);
        chk("R8 prescaler restarted (127)", int'(v), 0);
        run_edges(1);
        snapshot(v);
        chk("R8 prescaler restarted (128)", int'(v), 1);
    endtask

    task automatic t_pulse();
        clear_count();
        wr_bus(2'd2, 4'hF);
        chk("R10 flags cleared", int'(irq_flag), 0);
        run_edges(8 * 128 - 1);
        chk("R9 no pulse before fall", int'(irq_pulse), 0);
        clk_en = 1'b1;
        step(1);
        clk_en = 1'b0;
        chk("R9 32 Hz pulse", int'(irq_pulse), 4'b0001);
        step(1);
        chk("R9 pulse lasts one cycle", int'(irq_pulse), 0);
        chk("R9 32 Hz flag", int'(irq_flag), 4'b0001);
        wr_bus(2'd2, 4'b0001);
        chk("R10 flag cleared by write", int'(irq_flag), 0);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        clear_count();
        wr_bus(2'd2, 4'hF);
        run_edges(255 * 128);
        snapshot(v);
        chk("R2 count 0xFF", int'(v), 8'hFF);
        chk("R9 flags before 1 Hz fall", int'(irq_flag), 4'b0111);
        wr_bus(2'd2, 4'hF);
        run_edges(128);
        snapshot(v);
        chk("R2 wrap to zero", int'(v), 0);
        chk("R9 all taps fell at wrap", int'(irq_flag), 4'hF);
        wr_bus(2'd2, 4'b0101);
        chk("R10 partial clear", int'(irq_flag), 4'b1010);
        wr_bus(2'd0, 4'hF);
        chk("R10 write elsewhere ignored", int'(irq_flag), 4'b1010);
    endtask

    task automatic t_idle_bus();
        logic [3:0] d;
        clear_count();
        run_edges(5 * 128);
        bus_addr = 2'd0;
        bus_rd   = 1'b0;
        #1 chk("R11 no strobe reads zero", int'(bus_rdata), 0);
        @(negedge clk);
        rd_bus(2'd2, d);
        chk("R11 address 2 reads zero", int'(d), 0);
        rd_bus(2'd3, d);
        chk("R11 address 3 reads zero", int'(d), 0);
        rd_bus(2'd0, d);
        chk("R5 low nibble 5", int'(d), 5);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog: actual not finished expected finished");
        finish_run();
    end

    initial begin
        step(3);
        t_reset();
        t_count();
        t_enable_gate();
        t_stop();
        t_hold();
        t_carry_during_read();
        t_clear();
        t_pulse();
        t_wrap();
        t_idle_bus();
        finish_run();
    end
endmodule